// File: doc/BRIEF.md
# GPIO Output Register Change Notifier

This block holds the state of sixteen general-purpose output lines and is programmed one byte at a time over a small register bus. It has two registers, each three bytes wide: a data register and an enable register. The level driven on a line is its data bit ANDed with its enable bit, so a disabled line always reads as low.

Each write that lands on either register also checks the lines for a change. The block compares the new gated level with the level it last recorded. For every line that differs, it raises a one-cycle bit on an event vector, and it records the new level on a level vector in the same cycle. Downstream logic can therefore react only to lines that actually moved, without watching all sixteen levels.

Top module: `gpio_out_notifier`

## Requirements
- R1: While reset is asserted, and directly after it, `line_lvl` and `line_evt` are zero and every register byte reads back as zero.
- R2: A write with `we` high replaces only the addressed byte of a register and leaves its other bytes unchanged. Data bytes are at 0x78, 0x79 and 0x7A, and enable bytes are at 0x7C, 0x7D and 0x7E. Offset i from the base holds bits 8*i+7 down to 8*i.
- R3: `rdata` follows `addr` combinationally and returns the raw stored byte of the data or enable register, not the gated level.
- R4: One clock edge after a write to either register, `line_lvl` equals data AND enable over bits 15..0.
- R5: At that same edge, `line_evt` has a 1 in exactly the bits where the new `line_lvl` differs from the previous one. The strobe lasts one cycle and then returns to zero.
- R6: A write that leaves the gated level unchanged produces an all-zero `line_evt`. This covers changing data bits whose enable is 0 and enabling lines whose data is 0.
- R7: Bits 23..16 of both registers are stored and read back, but never change `line_lvl` or `line_evt`.
- R8: Addresses outside the six register bytes read as zero. A write to such an address changes no register, produces no event and leaves `line_lvl` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| we | input | 1 | Byte write strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Readback byte for `addr` |
| line_lvl | output | 16 | Recorded gated output levels |
| line_evt | output | 16 | One-cycle per-line change strobe |

## Verification
The assertions check, on every cycle, that the event vector always equals the XOR of the current and previous level vectors. They also check that events and level changes happen only in the cycle after a write, and that both outputs sit at zero during reset. What only the bench scenarios can show is the arithmetic of the registers: how byte lanes merge, that the enable gates the data, that the upper byte has no effect, and that unmapped addresses are ignored. These are checked against levels the bench works out itself from the write sequence.

// File: rtl/gpio_out_notifier.sv
module gpio_out_notifier #(
  parameter int         NLINES    = 16,
  parameter int         LANES     = 3,
  parameter int         AW        = 8,
  parameter logic [7:0] DATA_BASE = 8'h78,
  parameter logic [7:0] OE_BASE   = 8'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NLINES-1:0] line_lvl,
  output logic [NLINES-1:0] line_evt
);
  localparam int RW = LANES * 8;

  logic [RW-1:0]     data_q, oe_q, data_n, oe_n;
  logic [NLINES-1:0] eff_n;
  logic              hit;

  always_comb begin
    data_n = data_q;
    oe_n   = oe_q;
    hit    = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (we && addr == AW'(DATA_BASE + i)) begin
        data_n[8*i +: 8] = wdata;
        hit = 1'b1;
      end
      if (we && addr == AW'(OE_BASE + i)) begin
        oe_n[8*i +: 8] = wdata;
        hit = 1'b1;
      end
    end
  end

  assign eff_n = data_n[NLINES-1:0] & oe_n[NLINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      oe_q     <= '0;
      line_lvl <= '0;
      line_evt <= '0;
    end else begin
      data_q <= data_n;
      oe_q   <= oe_n;
      if (hit) begin
        line_evt <= eff_n ^ line_lvl;
        line_lvl <= eff_n;
      end else begin
        line_evt <= '0;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < LANES; i++) begin
      if (addr == AW'(DATA_BASE + i)) rdata = data_q[8*i +: 8];
      if (addr == AW'(OE_BASE + i))   rdata = oe_q[8*i +: 8];
    end
  end
endmodule

module gpio_out_notifier_chk #(
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [NLINES-1:0] line_lvl,
  input logic [NLINES-1:0] line_evt
);
  // R5
  evt_matches_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt == (line_lvl ^ $past(line_lvl)));
  // R5
  evt_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt != '0) |-> $past(we));
  // R8
  lvl_hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(line_lvl));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (line_evt == '0 && line_lvl == '0));
endmodule

bind gpio_out_notifier gpio_out_notifier_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .line_lvl(line_lvl), .line_evt(line_evt)
);

// File: tb/gpio_out_notifier_test.sv
module gpio_out_notifier_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [15:0] line_lvl, line_evt;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  gpio_out_notifier uut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .line_lvl(line_lvl), .line_evt(line_evt)
  );

  // {addr, wdata, expected evt, expected lvl}
  localparam int NV = 11;
  localparam logic [47:0] VEC [NV] = '{
    {8'h78, 8'hFF, 16'h0000, 16'h0000},  // R6 data without enable
    {8'h7C, 8'h0F, 16'h000F, 16'h000F},  // R4 R5
    {8'h7D, 8'hFF, 16'h0000, 16'h000F},  // R6 enable over zero data
    {8'h79, 8'hA5, 16'hA500, 16'hA50F},  // R2 R5
    {8'h78, 8'h03, 16'h000C, 16'hA503},  // R2 R5
    {8'h7C, 8'hFF, 16'h0000, 16'hA503},  // R6
    {8'h7A, 8'h5A, 16'h0000, 16'hA503},  // R7
    {8'h7E, 8'hFF, 16'h0000, 16'hA503},  // R7
    {8'h7B, 8'hFF, 16'h0000, 16'hA503},  // R8
    {8'h7D, 8'h00, 16'hA500, 16'h0003},  // R4 R5
    {8'h78, 8'h01, 16'h0002, 16'h0001}   // R5
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lvl", line_lvl, 16'h0000);
    chk("R1 evt", line_evt, 16'h0000);
    rst_n = 1'b1;
    rd("R1 data0", 8'h78, 8'h00);
    rd("R1 oe0", 8'h7C, 8'h00);

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][47:40], VEC[k][39:32]);
      chk($sformatf("R5 evt vec%0d", k), line_evt, VEC[k][31:16]);
      chk($sformatf("R4 lvl vec%0d", k), line_lvl, VEC[k][15:0]);
      @(negedge clk);
      chk($sformatf("R5 strobe width vec%0d", k), line_evt, 16'h0000);
    end

    rd("R2 data lane0", 8'h78, 8'h01);
    rd("R3 raw data lane1", 8'h79, 8'hA5);
    rd("R7 data lane2", 8'h7A, 8'h5A);
    rd("R2 oe lane0", 8'h7C, 8'hFF);
    rd("R2 oe lane1", 8'h7D, 8'h00);
    rd("R7 oe lane2", 8'h7E, 8'hFF);
    rd("R8 hole 0x7B", 8'h7B, 8'h00);
    rd("R8 addr 0x00", 8'h00, 8'h00);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 lvl after reset", line_lvl, 16'h0000);
    chk("R1 evt after reset", line_evt, 16'h0000);
    rst_n = 1'b1;
    rd("R1 data lane1 after reset", 8'h79, 8'h00);
    rd("R1 oe lane2 after reset", 8'h7E, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule